// File: doc/BRIEF.md
# Bitmap-Compressed Table Chunk Lookup Engine

This block resolves a single lookup in one chunk of a compressed classification table. A chunk stands for 32 logical 16-bit entries. Runs of equal neighbouring entries are stored once, so the chunk is kept as a short record. The record's first word is a 32-bit bitmap. A 1 in the bitmap marks the offset at which a new distinct element begins, and bit 0 is always 1. Up to four further words follow the bitmap and hold the first eight distinct elements, two 16-bit elements to a word. Any distinct element beyond the eighth sits in a separate overflow table, again packed two per word.

A caller presents a record base address, an overflow-table base address and a 5-bit entry offset. The engine reads the bitmap word. It counts the ones in the bitmap from bit 0 up to and including the offset, and subtracts one to get the element index. It then reads only the single word that holds that element, picks the correct half of it, and returns the element with a one-cycle valid pulse. Every lookup therefore costs exactly two memory reads. The memory port uses a request/grant handshake with a read-data-valid strobe of variable latency, and only one read is ever outstanding.

Top module: `bmlk_engine`

## Requirements
- R1: While reset is held, and right after it is released, req_ready is 1, mem_req is 0 and res_valid is 0.
- R2: A lookup is taken only in a cycle where req_valid and req_ready are both 1. req_ready stays 0 until that lookup's result pulse has ended. A req_valid raised while busy has no effect on the result or on the reads.
- R3: The first read of every lookup is at the record base address. This word is the bitmap.
- R4: The element index is popcount(bitmap & ((2 << offset) - 1)) - 1. When the index is below 8, the second and last read is at record base + 1 + index/2.
- R5: An even index returns bits [15:0] of the element word. An odd index returns bits [31:16].
- R6: When the index is 8 or more, the second read is at overflow base + (index - 8)/2. The half is still chosen by index parity.
- R7: mem_req stays high with a stable mem_addr until a cycle with mem_gnt. After a grant, no new request is raised until read data has returned. Any read latency is accepted.
- R8: res_valid is high for exactly one cycle, in the cycle after the element word's mem_rvalid, with res_data holding the element.
- R9: Asserting reset during a lookup abandons it. No result pulse follows, and the next lookup after reset completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ready | output | 1 | Engine idle, able to take a lookup |
| req_base | input | AW | Word address of the chunk record (bitmap word) |
| req_acc_base | input | AW | Word address of the chunk's overflow elements |
| req_offset | input | 5 | Logical entry offset within the chunk |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read word address |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Looked-up 16-bit element |

## Verification
The bench covers several boundary cases. One is a single-element bitmap at offset 31, where an inclusive mask that is off by one would give index 0 or overflow the count. Another is a full bitmap at offsets 7, 8, 9 and 31, the crossing from inline words into the overflow table, where a design with the wrong threshold or subtraction would read the wrong address. A third is a bitmap whose last set bit is bit 31, together with offsets that land just below and on set bits, which exposes a mask that excludes the requested bit. Grant delays and read latencies are varied, requests raised while busy must not disturb the result, and a reset in mid-lookup must not leave a stale read that produces a late pulse or a swapped half.

// File: rtl/bmlk_pkg.sv
package bmlk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAP_REQ,
    ST_MAP_WAIT,
    ST_ELT_REQ,
    ST_ELT_WAIT,
    ST_RESP
  } bmlk_state_e;
endpackage

// File: rtl/bmlk_popcnt.sv
module bmlk_popcnt #(
  parameter int N  = 32,
  parameter int OW = 5
) (
  input  logic [N-1:0]  bits,
  input  logic [OW-1:0] off,
  output logic [OW-1:0] idx
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  mask;
  logic [N-1:0]  masked;
  logic [CW-1:0] cnt;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign mask[g] = (off >= OW'(g));
  end

  assign masked = bits & mask;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(masked[i]);
    end
    if (cnt == '0) begin
      idx = '0;
    end else begin
      idx = OW'(cnt - CW'(1));
    end
  end
endmodule

// File: rtl/bmlk_addr.sv
module bmlk_addr #(
  parameter int AW     = 16,
  parameter int OW     = 5,
  parameter int SW     = 1,
  parameter int INLINE = 8
) (
  input  logic [OW-1:0] idx,
  input  logic [AW-1:0] rec_base,
  input  logic [AW-1:0] acc_base,
  output logic [AW-1:0] elt_addr
);
  logic          is_inline;
  logic [OW-1:0] ovf_idx;

  assign is_inline = (idx < OW'(INLINE));
  assign ovf_idx   = idx - OW'(INLINE);

  always_comb begin
    if (is_inline) begin
      elt_addr = rec_base + AW'(1) + AW'(idx >> SW);
    end else begin
      elt_addr = acc_base + AW'(ovf_idx >> SW);
    end
  end
endmodule

// File: rtl/bmlk_unpack.sv
module bmlk_unpack #(
  parameter int DW = 32,
  parameter int EW = 16,
  parameter int SW = 1
) (
  input  logic [DW-1:0] word,
  input  logic [SW-1:0] sel,
  output logic [EW-1:0] elem
);
  localparam int LANES = DW / EW;

  logic [EW-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[g*EW +: EW];
  end

  assign elem = lane[sel];
endmodule

// File: rtl/bmlk_engine.sv
module bmlk_engine #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int EW     = 16,
  parameter int INLINE = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [AW-1:0]            req_base,
  input  logic [AW-1:0]            req_acc_base,
  input  logic [$clog2(DW)-1:0]    req_offset,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_gnt,
  input  logic                     mem_rvalid,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     res_valid,
  output logic [EW-1:0]            res_data
);
  import bmlk_pkg::*;

  localparam int OW = $clog2(DW);
  localparam int SW = $clog2(DW / EW);

  bmlk_state_e   state_q, state_d;
  logic [AW-1:0] base_q;
  logic [AW-1:0] acc_q;
  logic [OW-1:0] off_q;
  logic [OW-1:0] idx_q;
  logic [EW-1:0] res_q;

  logic          accept;
  logic          cap_idx;
  logic          cap_res;
  logic [OW-1:0] idx_new;
  logic [AW-1:0] elt_addr;
  logic [EW-1:0] elem;

  bmlk_popcnt #(.N(DW), .OW(OW)) u_popcnt (
    .bits (mem_rdata),
    .off  (off_q),
    .idx  (idx_new)
  );

  bmlk_addr #(.AW(AW), .OW(OW), .SW(SW), .INLINE(INLINE)) u_addr (
    .idx      (idx_q),
    .rec_base (base_q),
    .acc_base (acc_q),
    .elt_addr (elt_addr)
  );

  bmlk_unpack #(.DW(DW), .EW(EW), .SW(SW)) u_unpack (
    .word (mem_rdata),
    .sel  (idx_q[SW-1:0]),
    .elem (elem)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cap_idx   = (state_q == ST_MAP_WAIT) && mem_rvalid;
  assign cap_res   = (state_q == ST_ELT_WAIT) && mem_rvalid;
  assign mem_req   = (state_q == ST_MAP_REQ) || (state_q == ST_ELT_REQ);
  assign mem_addr  = (state_q == ST_MAP_REQ) ? base_q : elt_addr;
  assign res_valid = (state_q == ST_RESP);
  assign res_data  = res_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req_valid)  state_d = ST_MAP_REQ;
      ST_MAP_REQ:  if (mem_gnt)    state_d = ST_MAP_WAIT;
      ST_MAP_WAIT: if (mem_rvalid) state_d = ST_ELT_REQ;
      ST_ELT_REQ:  if (mem_gnt)    state_d = ST_ELT_WAIT;
      ST_ELT_WAIT: if (mem_rvalid) state_d = ST_RESP;
      ST_RESP:                     state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      base_q <= req_base;
      acc_q  <= req_acc_base;
      off_q  <= req_offset;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_idx) begin
      idx_q <= idx_new;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_res) begin
      res_q <= elem;
    end
  end
endmodule

// File: rtl/bmlk_engine_chk.sv
module bmlk_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_base,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          res_valid
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R7

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> !mem_req); // R7

  AST_FIRST_READ_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req && (mem_addr == $past(req_base))); // R3

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R2

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid && req_ready); // R8

  AST_RESULT_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready && !mem_req); // R8
endmodule

bind bmlk_engine bmlk_engine_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_base  (req_base),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_gnt   (mem_gnt),
  .res_valid (res_valid)
);

// File: tb/bmlk_engine_test.sv
module bmlk_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  // {record[11:10], offset[9:5], expected index[4:0]}
  localparam logic [11:0] VEC [16] = '{
    {2'd0, 5'd0,  5'd0},  {2'd0, 5'd31, 5'd0},
    {2'd1, 5'd0,  5'd0},  {2'd1, 5'd1,  5'd1},
    {2'd1, 5'd7,  5'd7},  {2'd1, 5'd8,  5'd8},
    {2'd1, 5'd9,  5'd9},  {2'd1, 5'd31, 5'd31},
    {2'd2, 5'd7,  5'd0},  {2'd2, 5'd8,  5'd1},
    {2'd2, 5'd16, 5'd2},  {2'd2, 5'd30, 5'd2},
    {2'd2, 5'd31, 5'd3},  {2'd3, 5'd12, 5'd12},
    {2'd3, 5'd20, 5'd12}, {2'd3, 5'd5,  5'd5}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_base = '0;
  logic [AW-1:0] req_acc_base = '0;
  logic [4:0]    req_offset = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_gnt = 1'b0;
  logic          mem_rvalid = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          res_valid;
  logic [15:0]   res_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [256];
  int lat = 0, gdly = 0;
  int cnt = 0, wcnt = 0;
  bit pend = 0, prev_wait = 0;
  logic [AW-1:0] paddr = '0, prev_addr = '0;
  int rd_n = 0;
  logic [AW-1:0] rd_a [8];
  int hold_err = 0, ovl_err = 0;

  bmlk_engine #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_acc_base(req_acc_base), .req_offset(req_offset),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_data(res_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ev(input int r, input int k);
    return {4'hA, 4'(r), 3'b000, 5'(k)};
  endfunction

  function automatic logic [AW-1:0] rec_base(input int r);
    return AW'(r * 8);
  endfunction

  function automatic logic [AW-1:0] ovf_base(input int r);
    return AW'(128 + r * 16);
  endfunction

  function automatic logic [AW-1:0] elt_word(input int r, input int k);
    if (k < 8) return rec_base(r) + AW'(1 + k / 2);
    return ovf_base(r) + AW'((k - 8) / 2);
  endfunction

  // memory model, acting on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0; mem_rvalid = 0; mem_gnt = 0; wcnt = 0; prev_wait = 0;
    end else begin
      mem_rvalid = 0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rvalid = 1; mem_rdata = mem[paddr[7:0]]; pend = 0;
        end else cnt = cnt - 1;
      end
      if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err++;
      if (mem_req && pend) ovl_err++;
      mem_gnt = 0;
      if (mem_req && !pend && !mem_rvalid) begin
        if (wcnt >= gdly) begin
          mem_gnt = 1; pend = 1; paddr = mem_addr; cnt = lat; wcnt = 0;
          if (rd_n < 8) rd_a[rd_n] = mem_addr;
          rd_n++;
        end else wcnt++;
      end
      prev_wait = mem_req && !mem_gnt;
      prev_addr = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input int r, input int off, input int k, input bit busy_poke);
    string tg;
    int n;
    tg = (k >= 8) ? "R6" : ((k % 2) ? "R5" : "R4");
    rd_n = 0;
    @(negedge clk);
    req_valid = 1; req_base = rec_base(r); req_acc_base = ovf_base(r);
    req_offset = 5'(off);
    @(negedge clk);
    req_valid = 0;
    if (busy_poke) begin
      req_valid = 1; req_base = rec_base(1); req_acc_base = ovf_base(1);
      req_offset = 5'd31;
      chk(!req_ready, "R2", 32'(req_ready), 0);
      @(negedge clk); @(negedge clk);
      req_valid = 0;
    end
    n = 0;
    while (!res_valid && n < 200) begin @(negedge clk); n++; end
    chk(res_valid, "R8", 32'(res_valid), 1);
    chk(res_data == ev(r, k), tg, 32'(res_data), 32'(ev(r, k)));
    chk(rd_n == 2, "R4", 32'(rd_n), 2);
    chk(rd_a[0] == rec_base(r), "R3", 32'(rd_a[0]), 32'(rec_base(r)));
    chk(rd_a[1] == elt_word(r, k), tg, 32'(rd_a[1]), 32'(elt_word(r, k)));
    @(negedge clk);
    chk(!res_valid, "R8", 32'(res_valid), 0);
    chk(req_ready, "R2", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] bm [4];
    bm[0] = 32'h0000_0001; bm[1] = 32'hFFFF_FFFF;
    bm[2] = 32'h8001_0101; bm[3] = 32'h0000_1FFF;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_BEEF;
    for (int r = 0; r < 4; r++) begin
      mem[rec_base(r)] = bm[r];
      for (int k = 0; k < 32; k++) begin
        if (k % 2 == 0) mem[elt_word(r, k)][15:0] = ev(r, k);
        else            mem[elt_word(r, k)][31:16] = ev(r, k);
      end
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(req_ready, "R1", 32'(req_ready), 1);
    chk(!mem_req, "R1", 32'(mem_req), 0);
    chk(!res_valid, "R1", 32'(res_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mem_req && !res_valid, "R1",
        {29'd0, req_ready, mem_req, res_valid}, 32'h4);

    // vector table walk, with varied grant delay and latency (R7)
    for (int i = 0; i < 16; i++) begin
      lat = i % 4; gdly = (i / 2) % 3;
      run(int'(VEC[i][11:10]), int'(VEC[i][9:5]), int'(VEC[i][4:0]), 1'b0);
    end

    // R2: requests raised while busy are ignored
    lat = 3; gdly = 1;
    run(2, 16, 2, 1'b1);

    // R9: reset mid-lookup
    lat = 5; gdly = 0; rd_n = 0;
    @(negedge clk);
    req_valid = 1; req_base = rec_base(1); req_acc_base = ovf_base(1);
    req_offset = 5'd20;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(req_ready && !mem_req, "R9", {30'd0, req_ready, mem_req}, 32'h2);
    rst_n = 1;
    begin
      int seen;
      seen = 0;
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        if (res_valid) seen++;
      end
      chk(seen == 0, "R9", 32'(seen), 0);
    end
    lat = 2; gdly = 2;
    run(3, 9, 9, 1'b0);   // R9: recovers after reset

    chk(hold_err == 0, "R7", 32'(hold_err), 0);
    chk(ovl_err == 0, "R7", 32'(ovl_err), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule